// File: doc/BRIEF.md
# Selective Replay Dependence Tracker

This block sits beside the entries of an instruction scheduler. It records, for each entry, which loads still in flight that instruction depends on, directly or through other instructions. A load in the memory pipeline can miss the cache after its dependents have already been issued on the assumption that it would hit. When that happens, the block invalidates only the instructions that depend on the missing load. Those instructions return to the pool that the select logic can pick from. Instructions that do not depend on the load keep going.

Each entry holds a small bit grid. There is one column per memory issue slot and one row per pipeline stage between schedule and execute. An issuing load sets the bit in its own column of row 0. An issuing instruction also takes the bitwise OR of the grids of up to two parent entries, named by index on the issue port. All grids move down one row per clock, so a load's bit always sits in the row of the stage that load currently occupies. When a kill arrives for a slot, every entry with a 1 in that column of the last row is invalidated. A 1 that moves out of the last row without a kill means the load hit, and the bit is dropped.

Each entry is a four-state machine:

| State | Meaning |
|---|---|
| FREE | Not in use. |
| WAIT | Allocated and eligible for select. |
| SHADOW | Issued, and still dependent on at least one unresolved load. |
| CLEAR | Issued, and free of any load dependence. |

The transitions are:

- FREE to WAIT, and any state to WAIT, on allocation.
- WAIT to SHADOW on an issue whose grid is not empty.
- WAIT to CLEAR on an issue whose grid is empty.
- SHADOW to WAIT on a matching kill (replay).
- SHADOW to CLEAR when the last bit shifts out.

An issue that is cancelled by a kill in the same cycle leaves the entry in WAIT.

Top module: `sel_replay_tracker`

## Requirements
- R1: After reset every entry is FREE: ready_o, safe_o and inval_o are all zero.
- R2: An allocation sets the entry to WAIT (ready_o bit high) with an empty grid. An issue request for an entry that is not in WAIT (FREE, SHADOW or CLEAR) is ignored.
- R3: A load issued in cycle t with slot s sets column s of row 0. The bit moves down one row per clock and sits in the last row (row 3) during cycle t+4. A kill for slot s invalidates dependents only in cycle t+4. A kill in any earlier or later cycle has no effect on that load's dependents.
- R4: An issuing instruction ORs the grids of its valid parent entries (src0, src1). Dependence is therefore transitive across chains, and an entry can depend on loads in both slots.
- R5: During a kill cycle, inval_o is high for every matching entry. On the next clock each such entry is back in WAIT with an empty grid. The load itself also carries its own bit and is invalidated.
- R6: Entries with no 1 in the killed column of the last row are not affected by the kill. This includes entries that depend on the other slot and entries with no load dependence.
- R7: A bit that shifts out of the last row without a kill is dropped. An issued entry whose grid becomes empty moves to CLEAR (safe_o high).
- R8: Suppose an instruction issues in the same cycle as a kill, and its parents' merged last row has a 1 in the killed slot. Then the issue is cancelled, its inval_o bit is high in that cycle, and it stays in WAIT. Without a kill, that last-row bit is dropped and the instruction enters CLEAR.
- R9: A non-load issue with no parent carrying a load bit enters CLEAR on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry |
| alloc_idx | input | 2 | Entry to allocate |
| iss_valid | input | 1 | Issue request |
| iss_idx | input | 2 | Entry being issued |
| iss_is_load | input | 1 | Issued instruction is a load |
| iss_slot | input | 1 | Memory issue slot of the issued load |
| src0_valid | input | 1 | First parent index valid |
| src0_idx | input | 2 | First parent entry |
| src1_valid | input | 1 | Second parent index valid |
| src1_idx | input | 2 | Second parent entry |
| kill_valid | input | 1 | A load in the last stage has missed |
| kill_slot | input | 1 | Slot of the missing load |
| ready_o | output | 4 | Per-entry: in WAIT, eligible for select |
| safe_o | output | 4 | Per-entry: issued with no pending load dependence |
| inval_o | output | 4 | Per-entry invalidate pulse, combinational in the kill cycle |

## Verification
The in-RTL assertions check properties that hold on every cycle:
- The grid moves down exactly one row per clock while an entry is in SHADOW.
- An entry in CLEAR holds an empty grid.
- A FREE entry stays FREE unless it is allocated.
- An invalidate pulse only appears together with a kill.
- A killed or cancelled entry is back in WAIT on the next clock.

Only the directed scenarios can show the rest. That includes whether the right entries match: transitive chains, dependence on two slots, kills for the wrong slot, and kills one cycle early or late. It also includes the race between a late-issuing child and a kill, and the point at which shadow entries become safe.

// File: rtl/srr_pkg.sv
package srr_pkg;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SHADOW = 2'd2,
        ST_CLEAR  = 2'd3
    } ent_state_e;

endpackage

// File: rtl/srr_dep_merge.sv
module srr_dep_merge #(
    parameter int ENTRIES = 4,
    parameter int ROWS    = 4,
    parameter int COLS    = 2,
    parameter int IDXW    = 2,
    parameter int SLOTW   = 1
) (
    input  logic [ENTRIES-1:0][ROWS-1:0][COLS-1:0] mats_i,
    input  logic                                   src0_v_i,
    input  logic [IDXW-1:0]                        src0_idx_i,
    input  logic                                   src1_v_i,
    input  logic [IDXW-1:0]                        src1_idx_i,
    input  logic                                   is_load_i,
    input  logic [SLOTW-1:0]                       slot_i,
    output logic [ROWS-1:0][COLS-1:0]              merged_o,
    output logic [COLS-1:0]                        last_o
);

    logic [ROWS-1:0][COLS-1:0] par0;
    logic [ROWS-1:0][COLS-1:0] par1;
    logic [ROWS-1:0][COLS-1:0] par_or;

    always_comb begin
        par0   = src0_v_i ? mats_i[src0_idx_i] : '0;
        par1   = src1_v_i ? mats_i[src1_idx_i] : '0;
        par_or = par0 | par1;
    end

    // Parents' grids advance with the clock edge that captures this issue;
    // the last row falls off (it is checked against the kill as last_o).
    always_comb begin
        merged_o = '0;
        for (int r = 1; r < ROWS; r++) begin
            merged_o[r] = par_or[r-1];
        end
        if (is_load_i) begin
            merged_o[0][slot_i] = 1'b1;
        end
        last_o = par_or[ROWS-1];
    end

endmodule

// File: rtl/srr_entry.sv
module srr_entry
    import srr_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 2,
    parameter int SLOTW = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_i,
    input  logic                      issue_i,
    input  logic                      cancel_i,
    input  logic [ROWS-1:0][COLS-1:0] merged_i,
    input  logic                      kill_valid_i,
    input  logic [SLOTW-1:0]          kill_slot_i,
    output logic [ROWS-1:0][COLS-1:0] mat_o,
    output logic                      ready_o,
    output logic                      safe_o,
    output logic                      inval_o
);

    ent_state_e                state_q, state_d;
    logic [ROWS-1:0][COLS-1:0] mat_q, mat_d;
    logic [ROWS-1:0][COLS-1:0] shifted;
    logic                      kill_hit;
    logic                      iss_take;
    logic                      fire;

    always_comb begin
        shifted = '0;
        for (int r = 1; r < ROWS; r++) begin
            shifted[r] = mat_q[r-1];
        end
    end

    assign kill_hit = (state_q == ST_SHADOW) && kill_valid_i && mat_q[ROWS-1][kill_slot_i];
    assign iss_take = issue_i && (state_q == ST_WAIT);
    assign fire     = iss_take && !cancel_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            mat_q   <= '0;
        end else begin
            state_q <= state_d;
            mat_q   <= mat_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        mat_d   = '0;
        if (alloc_i) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    state_d = ST_FREE;
                end
                ST_WAIT: begin
                    if (fire) begin
                        mat_d   = merged_i;
                        state_d = (merged_i != '0) ? ST_SHADOW : ST_CLEAR;
                    end
                end
                ST_SHADOW: begin
                    if (kill_hit) begin
                        state_d = ST_WAIT;
                    end else begin
                        mat_d   = shifted;
                        state_d = (shifted != '0) ? ST_SHADOW : ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    state_d = ST_CLEAR;
                end
                default: begin
                    state_d = ST_FREE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mat_o   = mat_q;
        ready_o = (state_q == ST_WAIT);
        safe_o  = (state_q == ST_CLEAR);
        inval_o = kill_hit || (iss_take && cancel_i);
    end

    a_r7_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (mat_q == '0));

    a_r3_shift_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHADOW && !kill_hit && !alloc_i)
        |=> (mat_q[ROWS-1:1] == $past(mat_q[ROWS-2:0])));

    a_r5_kill_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_hit && !alloc_i) |=> (state_q == ST_WAIT && mat_q == '0));

    a_r8_cancel_stays_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_take && cancel_i && !alloc_i) |=> (state_q == ST_WAIT));

    a_r2_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && !alloc_i) |=> (state_q == ST_FREE));

endmodule

// File: rtl/sel_replay_tracker.sv
module sel_replay_tracker #(
    parameter int ENTRIES = 4,
    parameter int ROWS    = 4,
    parameter int COLS    = 2,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SLOTW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [IDXW-1:0]    alloc_idx,
    input  logic               iss_valid,
    input  logic [IDXW-1:0]    iss_idx,
    input  logic               iss_is_load,
    input  logic [SLOTW-1:0]   iss_slot,
    input  logic               src0_valid,
    input  logic [IDXW-1:0]    src0_idx,
    input  logic               src1_valid,
    input  logic [IDXW-1:0]    src1_idx,
    input  logic               kill_valid,
    input  logic [SLOTW-1:0]   kill_slot,
    output logic [ENTRIES-1:0] ready_o,
    output logic [ENTRIES-1:0] safe_o,
    output logic [ENTRIES-1:0] inval_o
);

    logic [ENTRIES-1:0][ROWS-1:0][COLS-1:0] mats;
    logic [ROWS-1:0][COLS-1:0]              merged;
    logic [COLS-1:0]                        par_last;
    logic                                   cancel;

    srr_dep_merge #(
        .ENTRIES(ENTRIES),
        .ROWS   (ROWS),
        .COLS   (COLS),
        .IDXW   (IDXW),
        .SLOTW  (SLOTW)
    ) u_merge (
        .mats_i    (mats),
        .src0_v_i  (src0_valid),
        .src0_idx_i(src0_idx),
        .src1_v_i  (src1_valid),
        .src1_idx_i(src1_idx),
        .is_load_i (iss_is_load),
        .slot_i    (iss_slot),
        .merged_o  (merged),
        .last_o    (par_last)
    );

    assign cancel = kill_valid && par_last[kill_slot];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        srr_entry #(
            .ROWS (ROWS),
            .COLS (COLS),
            .SLOTW(SLOTW)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc_valid && (alloc_idx == IDXW'(i))),
            .issue_i     (iss_valid && (iss_idx == IDXW'(i))),
            .cancel_i    (cancel),
            .merged_i    (merged),
            .kill_valid_i(kill_valid),
            .kill_slot_i (kill_slot),
            .mat_o       (mats[i]),
            .ready_o     (ready_o[i]),
            .safe_o      (safe_o[i]),
            .inval_o     (inval_o[i])
        );
    end

    a_r5_inval_needs_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_o != '0) |-> kill_valid);

    a_r2_ready_safe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o & safe_o) == '0);

endmodule

// File: tb/sel_replay_tracker_test.sv
module sel_replay_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alloc_valid;
    logic [1:0] alloc_idx;
    logic       iss_valid;
    logic [1:0] iss_idx;
    logic       iss_is_load;
    logic       iss_slot;
    logic       src0_valid;
    logic [1:0] src0_idx;
    logic       src1_valid;
    logic [1:0] src1_idx;
    logic       kill_valid;
    logic       kill_slot;
    logic [3:0] ready_o;
    logic [3:0] safe_o;
    logic [3:0] inval_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sel_replay_tracker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_valid(alloc_valid),
        .alloc_idx  (alloc_idx),
        .iss_valid  (iss_valid),
        .iss_idx    (iss_idx),
        .iss_is_load(iss_is_load),
        .iss_slot   (iss_slot),
        .src0_valid (src0_valid),
        .src0_idx   (src0_idx),
        .src1_valid (src1_valid),
        .src1_idx   (src1_idx),
        .kill_valid (kill_valid),
        .kill_slot  (kill_slot),
        .ready_o    (ready_o),
        .safe_o     (safe_o),
        .inval_o    (inval_o)
    );

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid = 0; alloc_idx = 0;
        iss_valid = 0; iss_idx = 0; iss_is_load = 0; iss_slot = 0;
        src0_valid = 0; src0_idx = 0; src1_valid = 0; src1_idx = 0;
        kill_valid = 0; kill_slot = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic issue(input int idx, input logic ld, input logic slot,
                         input logic v0, input int p0, input logic v1, input int p1);
        iss_valid = 1; iss_idx = 2'(idx); iss_is_load = ld; iss_slot = slot;
        src0_valid = v0; src0_idx = 2'(p0); src1_valid = v1; src1_idx = 2'(p1);
    endtask

    task automatic kill(input logic slot);
        kill_valid = 1; kill_slot = slot;
        #1;
    endtask

    task automatic prep();
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1; alloc_idx = 2'(i);
            tick();
        end
        chk("R2", "ready after alloc", ready_o, 4'b1111);
    endtask

    task automatic t_reset();
        rst_n = 0;
        clear_in();
        tick(); tick();
        rst_n = 1;
        chk("R1", "ready at reset", ready_o, 4'b0000);
        chk("R1", "safe at reset", safe_o, 4'b0000);
        chk("R1", "inval at reset", inval_o, 4'b0000);
        issue(3, 0, 0, 0, 0, 0, 0);
        tick();
        chk("R2", "issue of free entry ignored (ready)", ready_o, 4'b0000);
        chk("R2", "issue of free entry ignored (safe)", safe_o, 4'b0000);
    endtask

    task automatic t_chain();
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        issue(1, 0, 0, 1, 0, 0, 0); tick();
        issue(2, 0, 0, 1, 1, 0, 0); tick();
        chk("R4", "chain in shadow, ready", ready_o, 4'b1000);
        chk("R4", "chain in shadow, safe", safe_o, 4'b0000);
        issue(3, 0, 0, 0, 0, 0, 0); tick();
        kill(0);
        chk("R4", "transitive chain invalidated", inval_o, 4'b0111);
        tick();
        chk("R5", "victims back in wait", ready_o, 4'b0111);
        chk("R9", "independent op safe and untouched", safe_o, 4'b1000);
    endtask

    task automatic t_wrong_slot();
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        issue(1, 0, 0, 1, 0, 0, 0); tick();
        tick(); tick();
        chk("R7", "bits held until last row", safe_o, 4'b0000);
        kill(1);
        chk("R6", "kill on other slot ignored", inval_o, 4'b0000);
        tick();
        chk("R7", "bits dropped after last row, safe", safe_o, 4'b0011);
        chk("R6", "no replay on other slot", ready_o, 4'b1100);
    endtask

    task automatic t_timing();
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        issue(1, 0, 0, 1, 0, 0, 0); tick();
        tick();
        kill(0);
        chk("R3", "kill one cycle early ignored", inval_o, 4'b0000);
        tick();
        tick();
        kill(0);
        chk("R3", "kill one cycle late ignored", inval_o, 4'b0000);
        chk("R3", "late kill leaves entries safe", safe_o, 4'b0011);
        tick();
    endtask

    task automatic t_two_slots();
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        issue(1, 1, 1, 0, 0, 0, 0); tick();
        issue(2, 0, 0, 1, 0, 1, 1); tick();
        issue(3, 0, 0, 1, 1, 0, 0); tick();
        kill(0);
        chk("R6", "slot0 kill hits only slot0 dependents", inval_o, 4'b0101);
        tick();
        kill(1);
        chk("R3", "slot1 kill one cycle later", inval_o, 4'b1010);
        tick();
        chk("R5", "all replayed", ready_o, 4'b1111);
        chk("R5", "none safe", safe_o, 4'b0000);
    endtask

    task automatic t_late_child();
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        tick(); tick(); tick();
        issue(1, 0, 0, 1, 0, 0, 0);
        kill(0);
        chk("R8", "late child cancelled with pulse", inval_o, 4'b0011);
        tick();
        chk("R8", "cancelled child stays ready", ready_o, 4'b1111);
        prep();
        issue(0, 1, 0, 0, 0, 0, 0); tick();
        tick(); tick(); tick();
        issue(1, 0, 0, 1, 0, 0, 0); tick();
        chk("R8", "late child without kill becomes safe", safe_o, 4'b0011);
        issue(1, 1, 1, 0, 0, 0, 0); tick();
        tick(); tick(); tick();
        kill(1);
        chk("R2", "reissue of safe entry ignored", inval_o, 4'b0000);
        tick();
        chk("R2", "safe entry unchanged", safe_o, 4'b0011);
    endtask

    initial begin
        t_reset();
        t_chain();
        t_wrong_slot();
        t_timing();
        t_two_slots();
        t_late_child();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule